// File: doc/BRIEF.md
# DMA Bus-Master Cycle Sequencer

This block lets an internal DMA engine borrow a shared system bus for exactly one memory read or write. When the engine posts a request, the sequencer asks the host for the bus with a hold-request line. It waits until it samples the hold acknowledge on a rising clock edge. It then runs one memory cycle and hands the bus back. All of its master-side pins are modelled as a value plus an output enable, so the chip's pad ring decides the actual high-impedance state.

The address is presented in two parts. The low part has dedicated pins. The upper byte shares its pins with the upper data lane: it is driven for a single address-phase cycle while an address strobe tells an external latch to capture it, and afterwards the same pins carry upper-lane data. Read and write strobes are active low. They last a minimum number of clocks and a READY input stretches them. A byte/word strap input and the low address bit decide which data lanes take part and how the upper-byte-enable pin is driven.

Top module: `dma_bus_seq`

## Requirements
- R1: While reset is asserted and after it is released, hold_req, addr_en, addr_stb and done are 0, and every output enable (addr_lo_oe, ad_hi_oe, dlo_oe, strobe_oe, ube_oe) is 0.
- R2: An idle block that samples xfer_req high on a rising edge latches the request fields and raises hold_req in the next cycle. No bus pin is enabled until hold_ack has been sampled high on a rising edge. The address phase starts in the cycle after that edge.
- R3: The address phase lasts exactly one cycle. In it addr_en=1 and addr_stb=1, addr_lo_o carries address bits [15:0], ad_hi_o carries address bits [23:16] with ad_hi_oe=1, and strobe_oe=1 with rd_n=wr_n=1.
- R4: The strobe phase follows. rd_n is low for a read and wr_n is low for a write, never both. The strobe stays low for at least STROBE_MIN cycles, and addr_en stays high while it is low.
- R5: The strobe ends at the first rising edge at which it has been low for at least STROBE_MIN cycles and ready is sampled high. Each edge that samples ready low after the minimum has been reached adds one more cycle of strobe.
- R6: Read data is captured at the edge where the strobe rises. done is high for exactly one cycle after that edge. rdata then holds {upper,lower} for a two-lane read and {8'h00, lane byte} for a one-lane read.
- R7: During a write, the strobe cycles and the one cycle after them drive the selected lanes. The lower lane (dlo_o) carries wdata[7:0]. The upper lane (ad_hi_o) carries wdata[15:8] for a two-lane write and wdata[7:0] for an upper-lane-only write.
- R8: With word_mode=1, lanes are chosen as follows. An odd address (bit 0 = 1) uses the upper lane only. An even address with xfer_wide=1 uses both lanes. An even address with xfer_wide=0 uses the lower lane only. ube_oe=1 during the bus phases, and ube_n=0 exactly when the upper lane is used.
- R9: With word_mode=0, every transfer uses the lower lane only, whatever xfer_wide and address bit 0 are. ube_oe stays 0, and ad_hi_oe is 0 outside the address phase.
- R10: In the cycle after done, hold_req, addr_en and all output enables are 0. The block then goes idle and carries out one transfer per accepted request.
- R11: During a read strobe the block drives neither data lane (ad_hi_oe=0, dlo_oe=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_mode | input | 1 | Bus width strap: 0 byte bus, 1 word bus |
| xfer_req | input | 1 | DMA engine request, sampled while idle |
| xfer_write | input | 1 | 1 write, 0 read |
| xfer_wide | input | 1 | Request a two-lane transfer (word bus, even address) |
| xfer_addr | input | 24 | Byte address of the transfer |
| xfer_wdata | input | 16 | Write data |
| hold_req | output | 1 | Bus request to the host |
| hold_ack | input | 1 | Bus grant from the host |
| ready | input | 1 | Wait-state input, low stretches the strobe |
| addr_en | output | 1 | Address enable while master |
| addr_stb | output | 1 | Strobe for the external upper-address latch |
| addr_lo_o | output | 16 | Low address pins value |
| addr_lo_oe | output | 1 | Low address pins drive enable |
| ad_hi_o | output | 8 | Shared upper address / upper data lane value |
| ad_hi_oe | output | 1 | Shared upper lane drive enable |
| ad_hi_i | input | 8 | Shared upper lane input |
| dlo_o | output | 8 | Lower data lane value |
| dlo_oe | output | 1 | Lower data lane drive enable |
| dlo_i | input | 8 | Lower data lane input |
| rd_n | output | 1 | Memory read strobe, active low |
| wr_n | output | 1 | Memory write strobe, active low |
| strobe_oe | output | 1 | Drive enable of rd_n and wr_n |
| ube_n | output | 1 | Upper byte enable, active low |
| ube_oe | output | 1 | Upper byte enable drive enable |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |

## Verification
A sequencer stuck in the wrong phase shows at the pins within one clock. The enables and strobes are decoded straight from the state, so the bench's model disagrees with addr_en, addr_stb or a strobe in the very cycle the state goes wrong. A wrong wait-state count shows as a strobe that rises one cycle early or late against the model's count of READY samples. A lane-selection fault shows as a wrong ube_n or a wrong lane enable from the address phase onward. A fault in packing the read data stays hidden until the done cycle, when rdata is compared.

// File: rtl/dma_bus_pkg.sv
package dma_bus_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_REQ   = 3'd1,
    SQ_ADDR  = 3'd2,
    SQ_STRB  = 3'd3,
    SQ_LATCH = 3'd4,
    SQ_REL   = 3'd5
  } seq_state_e;

  // bit 1: upper lane used, bit 0: lower lane used
  function automatic logic [1:0] pick_lanes(input logic wide_bus,
                                            input logic wide_req,
                                            input logic a0);
    if (!wide_bus)   return 2'b01;
    else if (a0)     return 2'b10;
    else if (wide_req) return 2'b11;
    else             return 2'b01;
  endfunction

  function automatic logic bus_owned(input seq_state_e s);
    return (s == SQ_ADDR) || (s == SQ_STRB) || (s == SQ_LATCH);
  endfunction

  function automatic logic data_held(input seq_state_e s);
    return (s == SQ_STRB) || (s == SQ_LATCH);
  endfunction

endpackage

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_bus_pkg::*;
#(
  parameter int STROBE_MIN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_req,
  input  logic       hold_ack,
  input  logic       ready,
  output seq_state_e state,
  output logic       accept,
  output logic       strobe_end
);
  localparam int CNT_W = $clog2(STROBE_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_MIN - 1);

  seq_state_e       nxt;
  logic [CNT_W-1:0] cnt;
  logic             min_met;

  assign accept     = (state == SQ_IDLE) && xfer_req;
  assign min_met    = (cnt >= CNT_LAST);
  assign strobe_end = (state == SQ_STRB) && min_met && ready;

  always_comb begin
    nxt = state;
    case (state)
      SQ_IDLE:  if (xfer_req) nxt = SQ_REQ;
      SQ_REQ:   if (hold_ack) nxt = SQ_ADDR;
      SQ_ADDR:  nxt = SQ_STRB;
      SQ_STRB:  if (strobe_end) nxt = SQ_LATCH;
      SQ_LATCH: nxt = SQ_REL;
      default:  nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state == SQ_ADDR)
        cnt <= '0;
      else if ((state == SQ_STRB) && !min_met)
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dma_bus_req_hold.sv
module dma_bus_req_hold #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              in_write,
  input  logic              in_wide,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              q_write,
  output logic              q_wide,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_wide  <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_write <= in_write;
      q_wide  <= in_wide;
      q_addr  <= in_addr;
      q_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/dma_bus_lanes.sv
module dma_bus_lanes
  import dma_bus_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int LOW_ADDR_W = 16,
  localparam int ADDR_W    = LOW_ADDR_W + LANE_W,
  localparam int DATA_W    = 2 * LANE_W
) (
  input  seq_state_e        state,
  input  logic              word_mode,
  input  logic [1:0]        lanes,
  input  logic              q_write,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [DATA_W-1:0] q_wdata,
  output logic              hold_req,
  output logic              addr_en,
  output logic              addr_stb,
  output logic [LOW_ADDR_W-1:0] addr_lo_o,
  output logic              addr_lo_oe,
  output logic [LANE_W-1:0] ad_hi_o,
  output logic              ad_hi_oe,
  output logic [LANE_W-1:0] dlo_o,
  output logic              dlo_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              strobe_oe,
  output logic              ube_n,
  output logic              ube_oe,
  output logic              done
);
  logic             owned, held, addr_ph;
  logic [LANE_W-1:0] hi_wdata;

  assign owned   = bus_owned(state);
  assign held    = data_held(state);
  assign addr_ph = (state == SQ_ADDR);

  assign hi_wdata = (lanes == 2'b11) ? q_wdata[DATA_W-1:LANE_W] : q_wdata[LANE_W-1:0];

  assign hold_req   = (state == SQ_REQ) || owned;
  assign addr_en    = owned;
  assign addr_stb   = addr_ph;
  assign addr_lo_oe = owned;
  assign addr_lo_o  = q_addr[LOW_ADDR_W-1:0];

  assign ad_hi_oe = addr_ph || (held && q_write && lanes[1]);
  assign ad_hi_o  = addr_ph ? q_addr[ADDR_W-1:LOW_ADDR_W] : hi_wdata;
  assign dlo_oe   = held && q_write && lanes[0];
  assign dlo_o    = q_wdata[LANE_W-1:0];

  assign strobe_oe = owned;
  assign rd_n      = !((state == SQ_STRB) && !q_write);
  assign wr_n      = !((state == SQ_STRB) && q_write);

  assign ube_oe = owned && word_mode;
  assign ube_n  = !lanes[1];
  assign done   = (state == SQ_LATCH);
endmodule

// File: rtl/dma_bus_rcap.sv
module dma_bus_rcap #(
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_end,
  input  logic              q_write,
  input  logic [1:0]        lanes,
  input  logic [LANE_W-1:0] hi_in,
  input  logic [LANE_W-1:0] lo_in,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [DATA_W-1:0] pack_read(input logic [1:0] ln,
                                                  input logic [LANE_W-1:0] hi,
                                                  input logic [LANE_W-1:0] lo);
    case (ln)
      2'b11:   return {hi, lo};
      2'b10:   return {{LANE_W{1'b0}}, hi};
      default: return {{LANE_W{1'b0}}, lo};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (strobe_end && !q_write)
      rdata <= pack_read(lanes, hi_in, lo_in);
  end
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_bus_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int LOW_ADDR_W = 16,
  parameter int STROBE_MIN = 2,
  localparam int ADDR_W    = LOW_ADDR_W + LANE_W,
  localparam int DATA_W    = 2 * LANE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_mode,
  input  logic                  xfer_req,
  input  logic                  xfer_write,
  input  logic                  xfer_wide,
  input  logic [ADDR_W-1:0]     xfer_addr,
  input  logic [DATA_W-1:0]     xfer_wdata,
  output logic                  hold_req,
  input  logic                  hold_ack,
  input  logic                  ready,
  output logic                  addr_en,
  output logic                  addr_stb,
  output logic [LOW_ADDR_W-1:0] addr_lo_o,
  output logic                  addr_lo_oe,
  output logic [LANE_W-1:0]     ad_hi_o,
  output logic                  ad_hi_oe,
  input  logic [LANE_W-1:0]     ad_hi_i,
  output logic [LANE_W-1:0]     dlo_o,
  output logic                  dlo_oe,
  input  logic [LANE_W-1:0]     dlo_i,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic                  strobe_oe,
  output logic                  ube_n,
  output logic                  ube_oe,
  output logic                  done,
  output logic [DATA_W-1:0]     rdata
);
  seq_state_e        state;
  logic              accept, strobe_end;
  logic              q_write, q_wide;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [1:0]        lanes;

  assign lanes = pick_lanes(word_mode, q_wide, q_addr[0]);

  dma_bus_fsm #(.STROBE_MIN(STROBE_MIN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .hold_ack(hold_ack),
    .ready(ready), .state(state), .accept(accept), .strobe_end(strobe_end)
  );

  dma_bus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .in_write(xfer_write), .in_wide(xfer_wide), .in_addr(xfer_addr), .in_wdata(xfer_wdata),
    .q_write(q_write), .q_wide(q_wide), .q_addr(q_addr), .q_wdata(q_wdata)
  );

  dma_bus_lanes #(.LANE_W(LANE_W), .LOW_ADDR_W(LOW_ADDR_W)) u_lanes (
    .state(state), .word_mode(word_mode), .lanes(lanes), .q_write(q_write),
    .q_addr(q_addr), .q_wdata(q_wdata),
    .hold_req(hold_req), .addr_en(addr_en), .addr_stb(addr_stb),
    .addr_lo_o(addr_lo_o), .addr_lo_oe(addr_lo_oe),
    .ad_hi_o(ad_hi_o), .ad_hi_oe(ad_hi_oe), .dlo_o(dlo_o), .dlo_oe(dlo_oe),
    .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe),
    .ube_n(ube_n), .ube_oe(ube_oe), .done(done)
  );

  dma_bus_rcap #(.LANE_W(LANE_W)) u_rcap (
    .clk(clk), .rst_n(rst_n), .strobe_end(strobe_end), .q_write(q_write),
    .lanes(lanes), .hi_in(ad_hi_i), .lo_in(dlo_i), .rdata(rdata)
  );

endmodule

// File: rtl/dma_bus_seq_checker.sv
module dma_bus_seq_checker #(
  parameter int STROBE_MIN = 2
) (
  input logic clk,
  input logic rst_n,
  input logic word_mode,
  input logic hold_req,
  input logic hold_ack,
  input logic ready,
  input logic addr_en,
  input logic addr_stb,
  input logic addr_lo_oe,
  input logic ad_hi_oe,
  input logic dlo_oe,
  input logic rd_n,
  input logic wr_n,
  input logic strobe_oe,
  input logic ube_oe,
  input logic done
);
  logic       strobe_low;
  logic [7:0] low_run;

  assign strobe_low = strobe_oe && !(rd_n && wr_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_run <= '0;
    else if (strobe_low)
      low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
    else
      low_run <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!hold_req && !addr_en && !strobe_oe && !ad_hi_oe && !dlo_oe && !ube_oe && !done));

  assert_master_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_en) |-> ($past(hold_ack) && $past(hold_req)));

  assert_addr_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |-> (addr_en && addr_lo_oe && ad_hi_oe && strobe_oe && rd_n && wr_n));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_oe |-> (rd_n || wr_n));

  assert_strobe_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_low && (low_run != 8'd0)) |-> (low_run >= 8'(STROBE_MIN)));

  assert_ready_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_low && !ready) |=> strobe_low);

  assert_byte_bus_no_ube_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> !ube_oe);

  assert_release_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!hold_req && !addr_en && !strobe_oe && !addr_lo_oe && !ad_hi_oe && !dlo_oe));

  assert_read_lanes_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_oe && !rd_n) |-> (!ad_hi_oe && !dlo_oe));

endmodule

bind dma_bus_seq dma_bus_seq_checker #(.STROBE_MIN(STROBE_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .hold_req(hold_req),
  .hold_ack(hold_ack), .ready(ready), .addr_en(addr_en), .addr_stb(addr_stb),
  .addr_lo_oe(addr_lo_oe), .ad_hi_oe(ad_hi_oe), .dlo_oe(dlo_oe),
  .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe), .ube_oe(ube_oe), .done(done)
);

// File: tb/dma_bus_seq_bench.sv
`timescale 1ns/1ps
module dma_bus_seq_bench;
  localparam int MINS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_mode = 1'b1;
  logic xfer_req = 1'b0, xfer_write = 1'b0, xfer_wide = 1'b0;
  logic [23:0] xfer_addr = '0;
  logic [15:0] xfer_wdata = '0;
  logic hold_ack = 1'b0, ready = 1'b1;
  logic [7:0] ad_hi_i = '0, dlo_i = '0;
  logic hold_req, addr_en, addr_stb, addr_lo_oe, ad_hi_oe, dlo_oe;
  logic rd_n, wr_n, strobe_oe, ube_n, ube_oe, done;
  logic [15:0] addr_lo_o, rdata;
  logic [7:0] ad_hi_o, dlo_o;

  int vectors = 0, errors = 0;
  int ack_delay = 0, ack_cnt = 0, wait_left = 0;
  bit started = 0, finished = 0;

  always #2 clk = ~clk;

  dma_bus_seq #(.STROBE_MIN(MINS)) u_dma_bus_seq (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .xfer_req(xfer_req),
    .xfer_write(xfer_write), .xfer_wide(xfer_wide), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .hold_req(hold_req), .hold_ack(hold_ack), .ready(ready),
    .addr_en(addr_en), .addr_stb(addr_stb), .addr_lo_o(addr_lo_o), .addr_lo_oe(addr_lo_oe),
    .ad_hi_o(ad_hi_o), .ad_hi_oe(ad_hi_oe), .ad_hi_i(ad_hi_i), .dlo_o(dlo_o),
    .dlo_oe(dlo_oe), .dlo_i(dlo_i), .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe),
    .ube_n(ube_n), .ube_oe(ube_oe), .done(done), .rdata(rdata)
  );

  // ---------------- behavioural reference ----------------
  // phase: 0 idle, 1 asking, 2 address, 3 strobe, 4 finish, 5 let go
  int          m_ph = 0, m_low = 0;
  bit          m_waited = 0, m_wr = 0, m_wide = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_wd = '0, m_rd = '0;

  function automatic bit uses_hi(bit wm, bit wide, bit a0);
    return wm && (a0 || wide);
  endfunction
  function automatic bit uses_lo(bit wm, bit wide, bit a0);
    return !wm || (!a0 && (wide || 1'b1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_low <= 0; m_waited <= 0; m_rd <= '0;
    end else begin
      case (m_ph)
        0: if (xfer_req) begin
             m_ph <= 1; m_wr <= xfer_write; m_wide <= xfer_wide;
             m_addr <= xfer_addr; m_wd <= xfer_wdata;
           end
        1: if (hold_ack) m_ph <= 2;
        2: begin m_ph <= 3; m_low <= 0; m_waited <= 0; end
        3: begin
             if ((m_low + 1 >= MINS) && ready) begin
               m_ph <= 4;
               if (!m_wr) begin
                 bit h, l;
                 h = uses_hi(word_mode, m_wide, m_addr[0]);
                 l = uses_lo(word_mode, m_wide, m_addr[0]);
                 if (h && l)      m_rd <= {ad_hi_i, dlo_i};
                 else if (h)      m_rd <= {8'h00, ad_hi_i};
                 else             m_rd <= {8'h00, dlo_i};
               end
             end else begin
               m_low <= m_low + 1;
               if (m_low + 1 >= MINS) m_waited <= 1;
             end
           end
        4: m_ph <= 5;
        default: m_ph <= 0;
      endcase
    end
  end

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !finished) begin
    string tg, lt, ut;
    bit bus, hi, lo, exp_hi_oe, exp_lo_oe;
    bus = (m_ph >= 2 && m_ph <= 4);
    hi  = uses_hi(word_mode, m_wide, m_addr[0]);
    lo  = uses_lo(word_mode, m_wide, m_addr[0]);
    case (m_ph)
      0, 1: tg = "R2";
      2: tg = "R3";
      3: tg = m_waited ? "R5" : "R4";
      4: tg = "R6";
      default: tg = "R10";
    endcase
    if (!rst_n) tg = "R1";
    lt = m_wr ? "R7" : "R11";
    if (!rst_n) lt = "R1";
    ut = word_mode ? "R8" : "R9";
    if (!rst_n) ut = "R1";
    chk(tg, "hold_req", 32'(hold_req), 32'(m_ph >= 1 && m_ph <= 4));
    chk(tg, "addr_en", 32'(addr_en), 32'(bus));
    chk(tg, "addr_stb", 32'(addr_stb), 32'(m_ph == 2));
    chk(tg, "addr_lo_oe", 32'(addr_lo_oe), 32'(bus));
    if (bus) chk("R3", "addr_lo_o", 32'(addr_lo_o), 32'(m_addr[15:0]));
    exp_hi_oe = (m_ph == 2) || ((m_ph == 3 || m_ph == 4) && m_wr && hi);
    exp_lo_oe = (m_ph == 3 || m_ph == 4) && m_wr && lo;
    chk((m_ph == 2) ? tg : lt, "ad_hi_oe", 32'(ad_hi_oe), 32'(exp_hi_oe));
    chk(lt, "dlo_oe", 32'(dlo_oe), 32'(exp_lo_oe));
    if (m_ph == 2) chk("R3", "ad_hi_o addr", 32'(ad_hi_o), 32'(m_addr[23:16]));
    else if (exp_hi_oe) chk("R7", "ad_hi_o data", 32'(ad_hi_o), 32'(lo ? m_wd[15:8] : m_wd[7:0]));
    if (exp_lo_oe) chk("R7", "dlo_o", 32'(dlo_o), 32'(m_wd[7:0]));
    chk(tg, "strobe_oe", 32'(strobe_oe), 32'(bus));
    if (bus) begin
      chk(tg, "rd_n", 32'(rd_n), 32'(!(m_ph == 3 && !m_wr)));
      chk(tg, "wr_n", 32'(wr_n), 32'(!(m_ph == 3 && m_wr)));
    end
    chk(ut, "ube_oe", 32'(ube_oe), 32'(bus && word_mode));
    if (bus && word_mode) chk("R8", "ube_n", 32'(ube_n), 32'(!hi));
    chk(tg, "done", 32'(done), 32'(m_ph == 4));
    if (m_ph == 4 && !m_wr) chk("R6", "rdata", 32'(rdata), 32'(m_rd));
  end

  // ---------------- host and memory responder ----------------
  always @(posedge clk) begin
    #1;
    if (!hold_req) begin
      hold_ack = 1'b0; ack_cnt = 0;
    end else if (!hold_ack) begin
      if (ack_cnt >= ack_delay) hold_ack = 1'b1;
      else ack_cnt++;
    end
    if (strobe_oe && !(rd_n && wr_n) && wait_left > 0) begin
      ready = 1'b0; wait_left--;
    end else begin
      ready = 1'b1;
    end
  end

  task automatic do_reset(input logic wm);
    @(posedge clk); #1;
    rst_n = 1'b0; word_mode = wm;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic xfer(input logic wr, input logic wide, input logic [23:0] a,
                      input logic [15:0] wd, input logic [7:0] mhi, input logic [7:0] mlo,
                      input int ackd, input int waits);
    @(posedge clk); #1;
    xfer_write = wr; xfer_wide = wide; xfer_addr = a; xfer_wdata = wd;
    ad_hi_i = mhi; dlo_i = mlo; ack_delay = ackd; wait_left = waits;
    xfer_req = 1'b1;
    @(posedge clk); #1;
    xfer_req = 1'b0;
    for (int i = 0; i < 100 && m_ph != 0; i++) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    started = 1;
    do_reset(1'b1);
    // word bus
    xfer(1'b0, 1'b1, 24'hA51234, 16'h0000, 8'hC3, 8'h3C, 0, 0);
    xfer(1'b0, 1'b0, 24'h7F0011, 16'h0000, 8'h99, 8'h11, 1, 3);
    xfer(1'b1, 1'b1, 24'h0200FE, 16'hBEEF, 8'h00, 8'h00, 3, 1);
    xfer(1'b1, 1'b0, 24'h123457, 16'h00AB, 8'h00, 8'h00, 0, 0);
    xfer(1'b1, 1'b0, 24'hFFFF00, 16'h5566, 8'h00, 8'h00, 2, 4);
    xfer(1'b0, 1'b0, 24'h000010, 16'h0000, 8'hEE, 8'h42, 0, 0);
    xfer(1'b0, 1'b1, 24'h00ABCD, 16'h0000, 8'h77, 8'h88, 0, 2);
    // byte bus
    do_reset(1'b0);
    xfer(1'b0, 1'b1, 24'h330002, 16'h0000, 8'hDD, 8'h5A, 0, 0);
    xfer(1'b1, 1'b1, 24'h440003, 16'hCAFE, 8'h00, 8'h00, 1, 2);
    xfer(1'b0, 1'b0, 24'h000001, 16'h0000, 8'h12, 8'h34, 0, 5);
    repeat (4) @(posedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=idle");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule